// File: doc/BRIEF.md
# Binary Field Multiply-Add Unit with Polynomial Register

This unit computes `(a · b mod g(x)) XOR c` over a binary extension field GF(2^m). Field addition is plain XOR, so the addend is folded into the product and there is no separate add path. The reducing polynomial g(x) is not an operand. It sits in a configuration register inside the unit. A write to that register decodes the field degree m once and keeps it, together with the reduction bits and the operand mask, in internal state. Every later multiply reuses these values and does not decode them again.

A multiply starts on a one-cycle `start` pulse while the unit is idle. It runs one shift-and-add step per clock over the bits of `b`. In each step the shifted copy of `a` is folded back into the field whenever its bit m becomes set. After m steps a one-cycle `done` pulse marks the new `result`, and that value is then held. The datapath width `XLEN` is a parameter.

In the configuration value, the highest set bit gives the degree. The bits below it are the low terms of g(x). A value with no bit set above bit 0 stands for degree `XLEN`, so the x^XLEN term never needs its own register bit.

Top module: `gfm_madd_unit`

## Requirements
- R1: Reset state. After reset `busy` and `done` are 0 and `result` is 0. The polynomial state is degree `XLEN` with low terms equal to 1, i.e. g(x) = x^XLEN + 1.
- R2: A `cfg_we` pulse while idle loads `cfg_poly`. The degree m becomes the index of the highest set bit. g(x) is x^m plus the bits of `cfg_poly` below m.
- R3: A `cfg_poly` value whose only possible set bit is bit 0 selects degree m = `XLEN`. The low terms are then that value itself.
- R4: `result` equals the field product of `op_a` and `op_b` modulo g(x), XOR `op_c`, taking all three operands as sampled on the accepting clock.
- R5: Operand bits at index m and above have no effect on `result`. They are cleared as the operands are sampled.
- R6: A `start` while idle and without `cfg_we` is accepted on that clock edge. `busy` is then high for exactly m cycles. `done` is high for one cycle, directly after the last `busy` cycle, and `busy` is 0 while `done` is high.
- R7: `result` changes only in the cycle in which `done` is high, and it holds its value between operations.
- R8: A `start` while `busy` is high is ignored. The running operation and its timing are unchanged.
- R9: A `cfg_we` while `busy` is high is ignored, so the polynomial in use stays unchanged. When `cfg_we` and `start` arrive together while idle, the write takes effect and the `start` is dropped.
- R10: With `cfg_poly` = 0b1011, 0b111 · 0b101 gives 0b110. With `cfg_poly` = 0x11B, 0x80 · 0x83 gives 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the polynomial register |
| cfg_poly | input | XLEN | Polynomial value to write |
| start | input | 1 | One-cycle request to begin a multiply-add |
| op_a | input | XLEN | Multiplicand |
| op_b | input | XLEN | Multiplier, scanned from bit 0 upward |
| op_c | input | XLEN | Addend, XORed into the product |
| busy | output | 1 | High while the iteration runs |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | XLEN | Last completed multiply-add value |

## Verification
Counting from the rising edge that accepts `start`, `busy` is high after that edge and falls after edge m, where m is the degree in force. `done` and the new `result` appear after that same edge m and last one cycle. A polynomial write changes state after its edge, and only the next accepted operation uses the new polynomial. The bench keeps a behavioural model that is updated on every rising edge from the same sampled inputs, and compares `busy`, `done` and `result` against it on every falling edge. Each operation's result is therefore checked exactly in the cycle it is due and again in every cycle it is held.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic {
        GFM_IDLE = 1'b0,
        GFM_RUN  = 1'b1
    } gfm_state_e;

    // bits needed to hold a degree in the range 1..xlen
    function automatic int gfm_degw(input int xlen);
        return $clog2(xlen + 1);
    endfunction

endpackage

// File: rtl/gfm_polyreg.sv
module gfm_polyreg #(
    parameter int XLEN = 16,
    parameter int DW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            lock,
    output logic [DW-1:0]   deg,
    output logic [XLEN-1:0] low,
    output logic [XLEN-1:0] opmask
);

    typedef struct packed {
        logic [DW-1:0]   deg;
        logic [XLEN-1:0] low;
        logic [XLEN-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        int top;
        cfg_d = cfg_q;
        top   = 0;
        if (we && !lock) begin
            for (int i = 1; i < XLEN; i++) begin
                if (wdata[i]) top = i;
            end
            if (top == 0) begin
                cfg_d.deg  = DW'(XLEN);
                cfg_d.mask = {XLEN{1'b1}};
                cfg_d.low  = wdata;
            end else begin
                cfg_d.deg  = DW'(top);
                cfg_d.mask = {XLEN{1'b1}} >> (XLEN - top);
                cfg_d.low  = wdata & ({XLEN{1'b1}} >> (XLEN - top));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.deg  <= DW'(XLEN);
            cfg_q.low  <= XLEN'(1);
            cfg_q.mask <= {XLEN{1'b1}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign deg    = cfg_q.deg;
    assign low    = cfg_q.low;
    assign opmask = cfg_q.mask;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(deg) && $stable(low))); // R9
    AST_DEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (deg != '0) && (deg <= DW'(XLEN))); // R2
    AST_LOW_BELOW_DEG: assert property (@(posedge clk) disable iff (!rst_n)
        (low & ~opmask) == '0); // R2

endmodule

// File: rtl/gfm_step.sv
module gfm_step #(
    parameter int XLEN = 16,
    parameter int DW   = 5
) (
    input  logic [XLEN-1:0] acc_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [DW-1:0]   deg,
    input  logic [XLEN-1:0] low,
    input  logic [XLEN-1:0] opmask,
    output logic [XLEN-1:0] acc_o,
    output logic [XLEN-1:0] a_o,
    output logic [XLEN-1:0] b_o
);

    logic [XLEN:0] shifted;
    logic          overflow;

    always_comb begin
        acc_o    = b_i[0] ? (acc_i ^ a_i) : acc_i;
        shifted  = {a_i, 1'b0};
        overflow = shifted[deg];
        a_o      = (shifted[XLEN-1:0] ^ (overflow ? low : '0)) & opmask;
        b_o      = b_i >> 1;
    end

endmodule

// File: rtl/gfm_madd_unit.sv
module gfm_madd_unit #(
    parameter int XLEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [XLEN-1:0] cfg_poly,
    input  logic            start,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_c,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    import gfm_pkg::*;

    localparam int DW = gfm_degw(XLEN);

    typedef struct packed {
        gfm_state_e      st;
        logic [DW-1:0]   cnt;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] acc;
        logic [XLEN-1:0] res;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DW-1:0]   deg;
    logic [XLEN-1:0] low;
    logic [XLEN-1:0] opmask;
    logic [XLEN-1:0] acc_n, a_n, b_n;

    gfm_polyreg #(.XLEN(XLEN), .DW(DW)) u_poly (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_poly),
        .lock   (busy),
        .deg    (deg),
        .low    (low),
        .opmask (opmask)
    );

    gfm_step #(.XLEN(XLEN), .DW(DW)) u_step (
        .acc_i  (ctl_q.acc),
        .a_i    (ctl_q.a),
        .b_i    (ctl_q.b),
        .deg    (deg),
        .low    (low),
        .opmask (opmask),
        .acc_o  (acc_n),
        .a_o    (a_n),
        .b_o    (b_n)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            GFM_IDLE: begin
                if (start && !cfg_we) begin
                    ctl_d.st  = GFM_RUN;
                    ctl_d.cnt = deg;
                    ctl_d.a   = op_a & opmask;
                    ctl_d.b   = op_b & opmask;
                    ctl_d.acc = op_c & opmask;
                end
            end
            default: begin
                ctl_d.a   = a_n;
                ctl_d.b   = b_n;
                ctl_d.acc = acc_n;
                ctl_d.cnt = ctl_q.cnt - DW'(1);
                if (ctl_q.cnt == DW'(1)) begin
                    ctl_d.st   = GFM_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = acc_n;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: GFM_IDLE, cnt: '0, a: '0, b: '0, acc: '0, res: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.st == GFM_RUN);
    assign done   = ctl_q.done;
    assign result = ctl_q.res;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R6
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cfg_we) |=> busy); // R6
    AST_WRITE_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we) |=> !busy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && ctl_q.cnt != DW'(1)) |=> busy); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.cnt != '0 && ctl_q.cnt <= deg)); // R6

endmodule

// File: tb/gfm_madd_unit_bench.sv
`timescale 1ns/1ps
module gfm_madd_unit_bench;
    localparam int XLEN = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [XLEN-1:0] cfg_poly = '0;
    logic            start = 1'b0;
    logic [XLEN-1:0] op_a = '0;
    logic [XLEN-1:0] op_b = '0;
    logic [XLEN-1:0] op_c = '0;
    logic            busy, done;
    logic [XLEN-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string drv_tag = "R4";

    always #2.5 clk = ~clk;

    gfm_madd_unit #(.XLEN(XLEN)) u_gfm_madd_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly(cfg_poly),
        .start(start), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int ref_deg(input logic [XLEN-1:0] pv);
        int m = 0;
        for (int i = 1; i < XLEN; i++) if (pv[i]) m = i;
        if (m == 0) m = XLEN;
        return m;
    endfunction

    // multiply as a full polynomial, then reduce from the top down
    function automatic logic [XLEN-1:0] ref_madd(input logic [XLEN-1:0] pv,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] c);
        int m = ref_deg(pv);
        longint unsigned msk = (64'd1 << m) - 1;
        longint unsigned g   = (longint'(pv) & msk) | (64'd1 << m);
        longint unsigned aa  = longint'(a) & msk;
        longint unsigned bb  = longint'(b) & msk;
        longint unsigned p   = 0;
        for (int i = 0; i < m; i++) if (bb[i]) p ^= (aa << i);
        for (int i = 2*m - 2; i >= m; i--) if (p[i]) p ^= (g << (i - m));
        p = (p ^ (longint'(c) & msk)) & msk;
        return XLEN'(p);
    endfunction

    // cycle model
    logic [XLEN-1:0] m_poly;
    logic            m_busy, m_done;
    int              m_cnt;
    logic [XLEN-1:0] m_pend, m_res;
    string           m_tag;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_poly <= XLEN'(1);
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
            m_pend <= '0;   m_res  <= '0;  m_tag <= "R1";
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end else if (cfg_we) begin
                m_poly <= cfg_poly;
            end else if (start) begin
                m_busy <= 1'b1;
                m_cnt  <= ref_deg(m_poly);
                m_pend <= ref_madd(m_poly, op_a, op_b, op_c);
                m_tag  <= drv_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R6 busy", busy, m_busy);
            check(done == m_done, "R6 done", done, m_done);
            check(result == m_res, {m_tag, " result"}, result, m_res);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic write_poly(input logic [XLEN-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_poly = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic run_op(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
            input logic [XLEN-1:0] c, input string tag, input bit lit, input logic [XLEN-1:0] exp);
        @(negedge clk); op_a = a; op_b = b; op_c = c; start = 1'b1; drv_tag = tag;
        @(negedge clk); start = 1'b0;
        while (!m_done) @(negedge clk);
        if (lit) check(result == exp, {tag, " literal"}, result, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(result == '0, "R1 result", result, 0);
        // R1/R3: default polynomial x^16+1, so x^15 * x = 1
        run_op(16'h8000, 16'h0002, 16'h0000, "R1", 1'b1, 16'h0001);
        // R3: explicit write of 1
        write_poly(16'h0001);
        run_op(16'h8000, 16'h0004, 16'h0000, "R3", 1'b1, 16'h0002);
        run_op(16'h1234, 16'hABCD, 16'h5A5A, "R3", 1'b0, '0);
        // R10: known products
        write_poly(16'h000B);
        run_op(16'h0007, 16'h0005, 16'h0000, "R10", 1'b1, 16'h0006);
        // R5: high operand bits ignored
        run_op(16'hFFF7, 16'hFF05, 16'h00F8, "R5", 1'b1, 16'h0006);
        write_poly(16'h011B);
        run_op(16'h0080, 16'h0083, 16'h0000, "R10", 1'b1, 16'h0001);
        // R4: addend folded in
        run_op(16'h0080, 16'h0083, 16'h00A5, "R4", 1'b1, 16'h00A4);
        // R8: start while busy
        @(negedge clk); op_a = 16'h0053; op_b = 16'h00CA; op_c = '0; start = 1'b1; drv_tag = "R8";
        @(negedge clk); op_a = 16'h00FF; op_b = 16'h00FF; op_c = 16'h0011;
        @(negedge clk); start = 1'b0;
        while (!m_done) @(negedge clk);
        check(result == 16'h0001, "R8 literal", result, 16'h0001);
        // R9: write while busy is ignored
        @(negedge clk); op_a = 16'h0002; op_b = 16'h0003; op_c = '0; start = 1'b1; drv_tag = "R9";
        @(negedge clk); start = 1'b0; cfg_we = 1'b1; cfg_poly = 16'h000B;
        @(negedge clk); cfg_we = 1'b0;
        while (!m_done) @(negedge clk);
        run_op(16'h0080, 16'h0083, 16'h0000, "R9", 1'b1, 16'h0001);
        // R9: write together with start while idle drops the start
        @(negedge clk); cfg_we = 1'b1; cfg_poly = 16'h000B; start = 1'b1;
        op_a = 16'h0007; op_b = 16'h0005; op_c = '0;
        @(negedge clk); cfg_we = 1'b0; start = 1'b0;
        check(busy == 1'b0, "R9 dropped start", busy, 0);
        run_op(16'h0007, 16'h0005, 16'h0000, "R9", 1'b1, 16'h0006);
        // R2/R4: random operands over several degrees
        write_poly(16'h000B);
        for (int k = 0; k < 20; k++) run_op(XLEN'($urandom), XLEN'($urandom), XLEN'($urandom), "R2", 1'b0, '0);
        write_poly(16'h011B);
        for (int k = 0; k < 20; k++) run_op(XLEN'($urandom), XLEN'($urandom), XLEN'($urandom), "R4", 1'b0, '0);
        write_poly(16'h1053);
        for (int k = 0; k < 20; k++) run_op(XLEN'($urandom), XLEN'($urandom), XLEN'($urandom), "R2", 1'b0, '0);
        write_poly(16'h0001);
        for (int k = 0; k < 20; k++) run_op(XLEN'($urandom), XLEN'($urandom), XLEN'($urandom), "R3", 1'b0, '0);
        // R7: result held while idle
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule